// File: doc/BRIEF.md
# Fractional Three-Stage Sampling Clock Divider

This block derives the timing of a sigma-delta converter front end from one fast master clock. It produces a one-cycle enable for the oversampling clock, which also acts as the serial shift clock, and a one-cycle frame-sync enable that marks each sample period. All outputs are clock enables in the master clock domain, so downstream logic stays on a single clock. The master clock passes through three cascaded counters: an integer prescaler M (1 to 4), a stage Q that also accepts half-integer ratios (4.5 to 8), and the oversampling ratio OVER (64 to 192). A 36.864 MHz source can therefore reach every common modem sample rate.

A 16-bit control word programs the three ratios. Reserved codes leave the earlier setting unchanged. A new word is staged and only replaces the running setting at a frame boundary, so a frame is never cut short. With the crystal-source input low, the prescalers are bypassed and every master clock cycle is a shift clock. In slave mode the block does not generate frame sync. Instead it receives the host's frame sync and raises an error pulse whenever the spacing between two host pulses is not OVER shift clocks.

Top module: `mq_clock_divider`

## Requirements
- R1: After reset the running setting is M=4, Q=6, OVER=160. The master frame period is 3840 master cycles, and shift clocks are 24 cycles apart. During reset fsyncEn and fsErr are low.
- R2: In master mode with the crystal source selected, fsyncEn pulses once every M*Q*OVER master cycles. The pulse coincides with the last shift clock of the frame.
- R3: A half-integer Q (cfgWord[11]=1) spaces successive shift clocks alternately M*floor(Q) and M*(floor(Q)+1) cycles apart. The shorter gap comes first after each frame boundary.
- R4: M is decoded from {cfgWord[13], cfgWord[12]} together with cfgWord[8]. Code 00 gives 3 (bit 8 clear) or 4 (bit 8 set). Code 11 gives 1 (bit 8 clear) or 2 (bit 8 set).
- R5: Q is decoded from cfgWord[11:9]: 000..011 give 5, 6, 7, 8, and 100..111 give 4.5, 5.5, 6.5, 7.5. OVER is decoded from cfgWord[5:3]: 000=160, 001=192, 101=64, 110=96, 111=128.
- R6: An M code of 01 or 10, or an OVER code of 010, 011 or 100, leaves that ratio at its previous valid value. The other fields of the same word still apply.
- R7: A word written with cfgWr takes effect only after the next frame boundary. The frame in progress keeps its old length.
- R8: With xtalMode low, oclkEn is high in every master cycle and fsyncEn pulses every OVER cycles, whatever M and Q are.
- R9: With masterMode low, fsyncEn stays low. fsErr pulses one cycle after a host pulse on extFsync when that pulse follows the previous host pulse by a count of shift clocks other than OVER. The count includes the shift clock in the pulse cycle. The first host pulse after entering slave mode is not checked.
- R10: In slave mode a host pulse on extFsync is the frame boundary. A staged word becomes the running setting there, and the spacing check at that same pulse still uses the old OVER.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| xtalMode | input | 1 | 1: divide through M and Q; 0: master clock is the shift clock |
| masterMode | input | 1 | 1: generate frame sync; 0: check host frame sync |
| cfgWr | input | 1 | Stage cfgWord in this cycle |
| cfgWord | input | 16 | Control word holding the M, Q and OVER fields |
| extFsync | input | 1 | Host frame-sync pulse (slave mode), one cycle wide |
| oclkEn | output | 1 | Oversampling and shift clock enable |
| fsyncEn | output | 1 | Generated frame-sync enable (master mode) |
| fsErr | output | 1 | Host frame-sync spacing error pulse |

## Verification
The hardest case to reach is the slave-mode boundary where a staged word is adopted. At that host pulse the spacing is still judged against the old ratio, and the following pulse is judged against the new one. The bench reaches it by entering slave mode in bypass, where every master cycle is a shift clock and spacings map exactly to cycle counts. It then stages a new OVER between two host pulses and places the following pulses at the old spacing, the new spacing and the old spacing again. The alternating half-integer gaps and the unchanged length of the frame in which a word is written are both measured directly on oclkEn and fsyncEn.

// File: rtl/mq_clock_divider_pkg.sv
package mq_clock_divider_pkg;

  localparam int CFG_W = 16;
  localparam int M_W   = 3;
  localparam int Q_W   = 4;
  localparam int OV_W  = 8;

  // control word field positions
  localparam int M_HI_POS   = 13;
  localparam int M_LO_POS   = 12;
  localparam int M_FINE_POS = 8;
  localparam int Q_MSB      = 11;
  localparam int Q_LSB      = 9;
  localparam int OV_MSB     = 5;
  localparam int OV_LSB     = 3;

  typedef struct packed {
    logic [M_W-1:0]  mDiv;
    logic [Q_W-1:0]  qBase;
    logic            qHalf;
    logic [OV_W-1:0] overRatio;
  } divSet_t;

  typedef struct packed {
    divSet_t set;
    logic    useXtal;
    logic    isMaster;
  } divCtl_t;

  localparam divSet_t RESET_SET = '{mDiv: M_W'(4), qBase: Q_W'(6), qHalf: 1'b0,
                                    overRatio: OV_W'(160)};

  // returns {valid, ratio}
  function automatic logic [M_W:0] decodeM(input logic hi, input logic lo, input logic fine);
    case ({hi, lo})
      2'b00:   decodeM = {1'b1, fine ? M_W'(4) : M_W'(3)};
      2'b11:   decodeM = {1'b1, fine ? M_W'(2) : M_W'(1)};
      default: decodeM = '0;
    endcase
  endfunction

  // returns {half, base}
  function automatic logic [Q_W:0] decodeQ(input logic [2:0] code);
    logic [Q_W-1:0] base;
    base = (code[2] ? Q_W'(4) : Q_W'(5)) + Q_W'(code[1:0]);
    decodeQ = {code[2], base};
  endfunction

  // returns {valid, ratio}
  function automatic logic [OV_W:0] decodeOver(input logic [2:0] code);
    case (code)
      3'b000:  decodeOver = {1'b1, OV_W'(160)};
      3'b001:  decodeOver = {1'b1, OV_W'(192)};
      3'b101:  decodeOver = {1'b1, OV_W'(64)};
      3'b110:  decodeOver = {1'b1, OV_W'(96)};
      3'b111:  decodeOver = {1'b1, OV_W'(128)};
      default: decodeOver = '0;
    endcase
  endfunction

endpackage

// File: rtl/mq_clock_divider_ctrl.sv
module mq_clock_divider_ctrl
  import mq_clock_divider_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             xtalMode,
  input  logic             masterMode,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             frameEnd,
  output divCtl_t          ctl
);

  localparam logic [CFG_W-1:0] USED_MASK =
      (CFG_W'(1) << M_HI_POS) | (CFG_W'(1) << M_LO_POS) | (CFG_W'(1) << M_FINE_POS) |
      (CFG_W'(7) << Q_LSB) | (CFG_W'(7) << OV_LSB);

  divSet_t pendSet;
  divSet_t actSet;
  logic [M_W:0]  mDec;
  logic [Q_W:0]  qDec;
  logic [OV_W:0] ovDec;
  logic          unusedCfg;

  assign unusedCfg = ^(cfgWord & ~USED_MASK);

  always_comb begin
    mDec  = decodeM(cfgWord[M_HI_POS], cfgWord[M_LO_POS], cfgWord[M_FINE_POS]);
    qDec  = decodeQ(cfgWord[Q_MSB:Q_LSB]);
    ovDec = decodeOver(cfgWord[OV_MSB:OV_LSB]);
  end

  // staged setting: reserved M / OVER codes keep what was there
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendSet <= RESET_SET;
    end else if (cfgWr) begin
      if (mDec[M_W])   pendSet.mDiv      <= mDec[M_W-1:0];
      if (ovDec[OV_W]) pendSet.overRatio <= ovDec[OV_W-1:0];
      pendSet.qHalf <= qDec[Q_W];
      pendSet.qBase <= qDec[Q_W-1:0];
    end
  end

  // running setting changes only on a frame boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         actSet <= RESET_SET;
    else if (frameEnd) actSet <= pendSet;
  end

  assign ctl.set      = actSet;
  assign ctl.useXtal  = xtalMode;
  assign ctl.isMaster = masterMode;

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |=> $stable(actSet));

  always_comb begin
    if (rstN) begin
      // R6
      m_legal_chk: assert (actSet.mDiv inside {M_W'(1), M_W'(2), M_W'(3), M_W'(4)})
        else $error("running M ratio outside decoded set");
      // R5
      over_legal_chk: assert (actSet.overRatio inside {OV_W'(64), OV_W'(96), OV_W'(128),
                                                       OV_W'(160), OV_W'(192)})
        else $error("running OVER ratio outside decoded set");
    end
  end

endmodule

// File: rtl/mq_clock_divider_dp.sv
module mq_clock_divider_dp
  import mq_clock_divider_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  divCtl_t ctl,
  input  logic    extFsync,
  output logic    oclkEn,
  output logic    fsyncEn,
  output logic    fsErr,
  output logic    frameEnd
);

  localparam int SC_W = OV_W + 1;
  localparam logic [SC_W-1:0] SC_MAX = '1;

  logic [M_W-1:0]  mCnt;
  logic [Q_W-1:0]  qCnt;
  logic            qPhase;
  logic [SC_W-1:0] frmCnt;
  logic            armed;
  logic [Q_W-1:0]  qLen;
  logic            mTick;
  logic            qTick;
  logic            lastSlot;
  logic [SC_W-1:0] measured;
  logic [SC_W-1:0] overExt;

  assign overExt  = SC_W'(ctl.set.overRatio);
  assign qLen     = ctl.set.qBase + Q_W'(ctl.set.qHalf & qPhase);
  assign mTick    = (mCnt == ctl.set.mDiv - M_W'(1));
  assign qTick    = mTick && (qCnt == qLen - Q_W'(1));
  assign oclkEn   = ctl.useXtal ? qTick : 1'b1;
  assign lastSlot = (frmCnt >= overExt - SC_W'(1));
  assign fsyncEn  = ctl.isMaster && oclkEn && lastSlot;
  assign frameEnd = ctl.isMaster ? fsyncEn : extFsync;
  assign measured = frmCnt + SC_W'(oclkEn);

  // prescaler M and fractional stage Q
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt   <= '0;
      qCnt   <= '0;
      qPhase <= 1'b0;
    end else if (!ctl.useXtal || frameEnd) begin
      mCnt   <= '0;
      qCnt   <= '0;
      qPhase <= 1'b0;
    end else begin
      mCnt <= mTick ? '0 : mCnt + M_W'(1);
      if (qTick) begin
        qCnt   <= '0;
        qPhase <= ctl.set.qHalf & ~qPhase;
      end else if (mTick) begin
        qCnt <= qCnt + Q_W'(1);
      end
    end
  end

  // oversampling stage: shift clocks since last frame boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          frmCnt <= '0;
    else if (frameEnd)                  frmCnt <= '0;
    else if (oclkEn && frmCnt != SC_MAX) frmCnt <= frmCnt + SC_W'(1);
  end

  // slave-mode spacing check
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
      fsErr <= 1'b0;
    end else begin
      fsErr <= !ctl.isMaster && extFsync && armed && (measured != overExt);
      if (ctl.isMaster) armed <= 1'b0;
      else if (extFsync) armed <= 1'b1;
    end
  end

  // R2
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    fsyncEn |=> (frmCnt == '0));

  // R4
  m_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    mCnt < ctl.set.mDiv);

  // R3
  q_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    qCnt < qLen);

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    fsErr |-> ($past(extFsync) && !$past(ctl.isMaster)));

endmodule

// File: rtl/mq_clock_divider.sv
module mq_clock_divider
  import mq_clock_divider_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             xtalMode,
  input  logic             masterMode,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             extFsync,
  output logic             oclkEn,
  output logic             fsyncEn,
  output logic             fsErr
);

  divCtl_t ctl;
  logic    frameEnd;

  mq_clock_divider_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .xtalMode   (xtalMode),
    .masterMode (masterMode),
    .cfgWr      (cfgWr),
    .cfgWord    (cfgWord),
    .frameEnd   (frameEnd),
    .ctl        (ctl)
  );

  mq_clock_divider_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .extFsync (extFsync),
    .oclkEn   (oclkEn),
    .fsyncEn  (fsyncEn),
    .fsErr    (fsErr),
    .frameEnd (frameEnd)
  );

endmodule

// File: tb/sim_mq_clock_divider.sv
module sim_mq_clock_divider;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xtalMode = 1'b1;
  logic        masterMode = 1'b1;
  logic        cfgWr = 1'b0;
  logic [15:0] cfgWord = '0;
  logic        extFsync = 1'b0;
  logic        oclkEn, fsyncEn, fsErr;

  int checks = 0;
  int fails = 0;
  int slaveFsync = 0;

  always #2 clk = ~clk;

  mq_clock_divider u0 (
    .clk(clk), .rstN(rstN), .xtalMode(xtalMode), .masterMode(masterMode),
    .cfgWr(cfgWr), .cfgWord(cfgWord), .extFsync(extFsync),
    .oclkEn(oclkEn), .fsyncEn(fsyncEn), .fsErr(fsErr)
  );

  typedef struct packed {
    logic [15:0] word;
    int          per;
    int          gap1;
    int          gap2;
  } vec_t;

  // word, frame period, first and second shift-clock gap
  localparam vec_t VECS [6] = '{
    '{16'h3828,  288,  4,  5},   // M1 Q4.5 OVER64
    '{16'h3F30, 1440, 14, 16},   // M2 Q7.5 OVER96
    '{16'h0038, 1920, 15, 15},   // M3 Q5   OVER128
    '{16'h0708, 6144, 32, 32},   // M4 Q8   OVER192
    '{16'h3A00,  880,  5,  6},   // M1 Q5.5 OVER160
    '{16'h3D28,  832, 12, 14}    // M2 Q6.5 OVER64
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at the negedge inside an fsync cycle; runs to the next fsync
  task automatic runFrame(input logic doWr, input int wrAt, input logic [15:0] w,
                          output int per, output int g1, output int g2, output int nOclk);
    int c = 0;
    int t1 = -1;
    int t2 = -1;
    logic done = 1'b0;
    nOclk = 0;
    while (!done) begin
      @(negedge clk);
      c++;
      if (cfgWr) cfgWr = 1'b0;
      if (doWr && c == wrAt) begin
        cfgWord = w;
        cfgWr = 1'b1;
      end
      if (oclkEn) begin
        nOclk++;
        if (t1 < 0) t1 = c;
        else if (t2 < 0) t2 = c;
      end
      if (fsyncEn || c > 20000) done = 1'b1;
    end
    per = c;
    g1 = t1;
    g2 = t2 - t1;
  endtask

  // host pulse n cycles after the previous one; returns fsErr seen after it
  task automatic hostPulse(input int n, input logic doWr, input logic [15:0] w,
                           output logic err);
    for (int i = 0; i < n - 1; i++) begin
      @(negedge clk);
      if (cfgWr) cfgWr = 1'b0;
      if (doWr && i == 0) begin
        cfgWord = w;
        cfgWr = 1'b1;
      end
      if (fsyncEn) slaveFsync++;
      if (i == n - 2) extFsync = 1'b1;
    end
    @(negedge clk);
    if (cfgWr) cfgWr = 1'b0;
    extFsync = 1'b0;
    err = fsErr;
  endtask

  initial begin
    int per, g1, g2, nOc, prev;
    logic err;

    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 fsyncEn in reset", int'(fsyncEn), 0);
    check("R1 fsErr in reset", int'(fsErr), 0);
    rstN = 1'b1;

    do @(negedge clk); while (!fsyncEn);
    runFrame(1'b0, 0, 16'h0, per, g1, g2, nOc);
    check("R1 reset frame period", per, 3840);
    check("R1 reset shift gap", g1, 24);

    prev = 3840;
    foreach (VECS[i]) begin
      runFrame(1'b1, 50, VECS[i].word, per, g1, g2, nOc);
      check("R7 frame during write keeps old length", per, prev);
      runFrame(1'b0, 0, 16'h0, per, g1, g2, nOc);
      check("R2 R4 R5 frame period", per, VECS[i].per);
      check("R3 first shift gap", g1, VECS[i].gap1);
      check("R3 second shift gap", g2, VECS[i].gap2);
      prev = VECS[i].per;
    end

    // R6: reserved M and OVER, Q=6 -> M2 Q6 OVER64
    runFrame(1'b1, 50, 16'h1210, per, g1, g2, nOc);
    check("R7 frame during reserved write", per, 832);
    runFrame(1'b0, 0, 16'h0, per, g1, g2, nOc);
    check("R6 reserved codes keep M and OVER", per, 768);
    check("R6 shift gap with Q6", g1, 12);

    // R8 bypass
    xtalMode = 1'b0;
    runFrame(1'b0, 0, 16'h0, per, g1, g2, nOc);
    check("R8 bypass frame period", per, 64);
    check("R8 bypass shift clock every cycle", nOc, 64);
    xtalMode = 1'b1;
    runFrame(1'b0, 0, 16'h0, per, g1, g2, nOc);
    runFrame(1'b0, 0, 16'h0, per, g1, g2, nOc);
    check("R2 period after bypass exit", per, 768);

    // R9 / R10 slave, bypass so shift clocks equal cycles
    masterMode = 1'b0;
    xtalMode = 1'b0;
    hostPulse(10, 1'b0, 16'h0, err);
    check("R9 first host pulse unchecked", int'(err), 0);
    hostPulse(64, 1'b0, 16'h0, err);
    check("R9 correct spacing", int'(err), 0);
    hostPulse(63, 1'b0, 16'h0, err);
    check("R9 short spacing flagged", int'(err), 1);
    hostPulse(64, 1'b0, 16'h0, err);
    check("R9 recovery after error", int'(err), 0);
    hostPulse(65, 1'b0, 16'h0, err);
    check("R9 long spacing flagged", int'(err), 1);
    hostPulse(64, 1'b1, 16'h3330, err);
    check("R10 old OVER at adopting pulse", int'(err), 0);
    hostPulse(96, 1'b0, 16'h0, err);
    check("R10 new OVER spacing accepted", int'(err), 0);
    hostPulse(64, 1'b0, 16'h0, err);
    check("R10 old spacing now flagged", int'(err), 1);
    check("R9 no generated fsync in slave", slaveFsync, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule